// File: doc/BRIEF.md
# Flow-through synchronous burst SRAM

A synchronous static RAM of 32-bit words, four byte lanes wide, meant to serve as the data array of a cache. The address, the write data and every control input except the output enable and the burst-order select are captured on the rising clock edge. A burst is opened by one of two address strobes. The strobe loads the external address, and an internal two-bit beat counter then walks through the four words of the aligned group. The counter moves only when the advance input is high. The order of the walk is linear or interleaved, chosen by a static select.

Reads are flow-through. The word at the current address passes combinationally from the array to the data output in the cycle after the capturing edge, with no output register. Writes take effect at the capturing edge itself, so no external write pulse is needed. Lanes are enabled one by one, or all together through a global write.

The controller is a four-state machine. IDLE means deselected. READ means a read cycle is in progress. WRITE means a write cycle is in progress. SLEEP means the block is asleep. The transitions are:
- The sleep input moves any state to SLEEP. When sleep falls, SLEEP returns to IDLE.
- A strobe with the chip select low moves any state to IDLE. This is the single-cycle deselect.
- The processor strobe with the chip select high goes to READ.
- The controller strobe with the chip select high goes to WRITE when a write is requested, and to READ otherwise.
- With no strobe, READ and WRITE continue the burst. They go to WRITE when a write is requested, and to READ otherwise.
- With no strobe, IDLE stays in IDLE.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and after it is released, the state is IDLE: dout_oe is 0, dout is 0, and burst_adv and write controls alone do not open a burst.
- R2: When sleep is low, an edge with strobe_cpu or strobe_ctl high loads addr as the burst base and clears the beat count. The access then uses addr exactly.
- R3: If strobe_cpu and strobe_ctl are both high in one edge, strobe_cpu wins. That cycle is a read, and all write inputs are ignored; the addressed word keeps its contents. strobe_ctl alone honours the write inputs.
- R4: With order_ilv low (linear order), each edge with burst_adv high and no strobe adds 1 to the beat. The low two address bits are (base[1:0] + beat) mod 4, and the beat wraps after four steps.
- R5: With order_ilv high (interleaved order), the low two address bits are base[1:0] XOR beat. The upper address bits never change within a burst.
- R6: An edge in a burst with no strobe and burst_adv low keeps the current address.
- R7: Lane i is data bits [8i+7:8i]. When wr_all is low, lane i is written at the edge only if byte_sel[i] and wr_en are both high. Other lanes keep their contents.
- R8: When wr_all is high, all four lanes are written regardless of wr_en and byte_sel. wr_en with all four byte_sel bits high also writes all lanes.
- R9: Read data flows through. After an edge that makes a read, dout shows the word at the current address during the following cycle. A word written at one edge is read back at the next read of that address.
- R10: oe acts without the clock. dout_oe equals oe AND (state is READ), and dout is 0 whenever dout_oe is 0.
- R11: dout_oe is 0 in the cycle after a write edge, and in the cycle after an edge with a strobe and chip_sel low.
- R12: While sleep is high, every clocked input is ignored, array contents are kept, and dout_oe is 0. After sleep falls, the block is in IDLE until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address loaded by a strobe |
| strobe_cpu | input | 1 | Processor-side address strobe; always starts a read |
| strobe_ctl | input | 1 | Controller-side address strobe |
| burst_adv | input | 1 | Advance the beat counter |
| chip_sel | input | 1 | Chip select, sampled with a strobe |
| wr_en | input | 1 | Write enable for the selected lanes |
| byte_sel | input | 4 | Per-lane write selects |
| wr_all | input | 1 | Global write of all lanes |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep input |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, 0 when not driven |
| dout_oe | output | 1 | High when dout is actively driven |

## Verification
Every clocked result is due in the cycle after the edge that captured the stimulus. This covers a load, an advance, a write and a state change. The bench drives inputs just after the falling edge and compares dout_oe and dout at the next falling edge, after a behavioural model has applied the same edge. The model holds its own address, beat, state and memory. The oe path has no register, so the bench also changes oe in the middle of a cycle and checks the outputs one time step later, without waiting for a clock edge.

// File: rtl/sync_burst_sram_pkg.sv
package sync_burst_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sram_state_e;

    // Low two address bits for a given base and beat
    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] beat,
                                               input logic       ilv);
        return ilv ? (base ^ beat) : (base + beat);
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import sync_burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] base_q, base_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    always_comb begin
        base_d = base_q;
        beat_d = beat_q;
        if (load) begin
            base_d = load_addr;
            beat_d = '0;
        end else if (advance) begin
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    assign cur_addr = {base_q[ADDR_W-1:BEAT_W], beat_offset(base_q[1:0], beat_q, order_ilv)};
    assign nxt_addr = {base_d[ADDR_W-1:BEAT_W], beat_offset(base_d[1:0], beat_d, order_ilv)};

    p_load_clears_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0) && (base_q == $past(load_addr)));
    p_advance_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> beat_q == $past(beat_q) + 1'b1);
    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(beat_q) && $stable(base_q));
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/write_lane_decode.sv
module write_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all,
    input  logic             wr_en,
    input  logic [LANES-1:0] byte_sel,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = wr_all | (wr_en & byte_sel[i]);
    end

    always_comb begin
        if (wr_all) a_global_all_r8: assert (&lane_we);
        if (!wr_en && !wr_all) a_no_enable_r7: assert (lane_we == '0);
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (lane_we[i])
                mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sync_burst_sram_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              burst_adv,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_sel,
    input  logic              wr_all,
    input  logic              order_ilv,
    input  logic              oe,
    input  logic              sleep,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    sram_state_e state_q, state_d;
    logic        any_strobe, active, load, advance, wr_req;
    logic [LANES-1:0]  lane_req, lane_we;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [DATA_W-1:0] rdata;

    assign any_strobe = strobe_cpu | strobe_ctl;
    assign active     = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign load       = !sleep && any_strobe;
    assign advance    = !sleep && !any_strobe && burst_adv && active;

    write_lane_decode #(.LANES(LANES)) u_dec (
        .wr_all   (wr_all),
        .wr_en    (wr_en),
        .byte_sel (byte_sel),
        .lane_we  (lane_req)
    );
    assign wr_req = |lane_req;

    // Next-state process
    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SLEEP: begin
                    if (strobe_cpu)      state_d = chip_sel ? ST_READ : ST_IDLE;
                    else if (strobe_ctl) state_d = !chip_sel ? ST_IDLE : (wr_req ? ST_WRITE : ST_READ);
                    else                 state_d = ST_IDLE;
                end
                ST_READ, ST_WRITE: begin
                    if (strobe_cpu)      state_d = chip_sel ? ST_READ : ST_IDLE;
                    else if (strobe_ctl) state_d = !chip_sel ? ST_IDLE : (wr_req ? ST_WRITE : ST_READ);
                    else                 state_d = wr_req ? ST_WRITE : ST_READ;
                end
                default:                 state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .load_addr (addr),
        .order_ilv (order_ilv),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    assign lane_we = (state_d == ST_WRITE) ? lane_req : '0;

    sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (nxt_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    // Output process
    always_comb begin
        dout_oe = 1'b0;
        dout    = '0;
        unique case (state_q)
            ST_READ: begin
                dout_oe = oe;
                dout    = oe ? rdata : '0;
            end
            ST_IDLE, ST_WRITE, ST_SLEEP: begin
                dout_oe = 1'b0;
            end
            default: dout_oe = 1'b0;
        endcase
    end

    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dout_oe);
    p_sleep_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> lane_we == '0);
    p_cpu_strobe_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe_cpu) |-> lane_we == '0);
    p_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && any_strobe && !chip_sel) |=> !dout_oe);
    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !dout_oe);
    p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sleep && !any_strobe) |=> !dout_oe);
    always_comb begin
        if (!oe) a_oe_gate_r10: assert (!dout_oe);
    end
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe_cpu = 0, strobe_ctl = 0, burst_adv = 0, chip_sel = 0;
    logic          wr_en = 0, wr_all = 0, order_ilv = 0, oe = 0, sleep = 0;
    logic [3:0]    byte_sel = '0;
    logic [31:0]   din = '0;
    logic [31:0]   dout;
    logic          dout_oe;

    sync_burst_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_cpu(strobe_cpu),
        .strobe_ctl(strobe_ctl), .burst_adv(burst_adv), .chip_sel(chip_sel),
        .wr_en(wr_en), .byte_sel(byte_sel), .wr_all(wr_all), .order_ilv(order_ilv),
        .oe(oe), .sleep(sleep), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 idle, 1 read, 2 write, 3 sleep
    int          m_state = 0;
    int          m_base = 0;
    int          m_beat = 0;
    logic [31:0] m_mem [DEPTH];
    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_req = "R1";
    bit          checking = 0;

    function automatic int m_addr(int base, int beat);
        int lo;
        lo = order_ilv ? ((base & 3) ^ beat) : (((base & 3) + beat) & 3);
        return (base & ~3) | lo;
    endfunction

    always @(posedge clk) begin
        if (rst_n && !sleep) begin
            bit      strobe, act, wreq;
            logic [3:0] lanes;
            int      nst, waddr;
            strobe = strobe_cpu || strobe_ctl;
            act    = (m_state == 1) || (m_state == 2);
            lanes  = wr_all ? 4'hF : (wr_en ? byte_sel : 4'h0);
            wreq   = (lanes != 0);
            if (strobe_cpu)      nst = chip_sel ? 1 : 0;
            else if (strobe_ctl) nst = !chip_sel ? 0 : (wreq ? 2 : 1);
            else if (act)        nst = wreq ? 2 : 1;
            else                 nst = 0;
            if (strobe) begin
                m_base = int'(addr);
                m_beat = 0;
            end else if (burst_adv && act) begin
                m_beat = (m_beat + 1) % 4;
            end
            if (nst == 2) begin
                waddr = m_addr(m_base, m_beat);
                for (int i = 0; i < 4; i++)
                    if (lanes[i]) m_mem[waddr][i*8 +: 8] = din[i*8 +: 8];
            end
            m_state = nst;
        end else if (rst_n && sleep) begin
            m_state = 3;
        end
    end

    task automatic compare();
        logic        e_oe;
        logic [31:0] e_dout;
        e_oe   = oe && (m_state == 1);
        e_dout = e_oe ? m_mem[m_addr(m_base, m_beat)] : 32'h0;
        n_cmp++;
        if (dout_oe !== e_oe || dout !== e_dout) begin
            n_bad++;
            $display("FAIL %s: dout_oe=%0b dout=%08h expected dout_oe=%0b dout=%08h",
                     cur_req, dout_oe, dout, e_oe, e_dout);
        end
    endtask

    always @(negedge clk) if (checking) compare();

    task automatic idle_in();
        strobe_cpu = 0; strobe_ctl = 0; burst_adv = 0; chip_sel = 0;
        wr_en = 0; wr_all = 0; byte_sel = '0;
    endtask

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        // R1: reset
        cur_req = "R1";
        #(CLK_PERIOD * 2 + 1);
        oe = 1; burst_adv = 1; wr_en = 1; byte_sel = 4'hF;
        compare();
        @(negedge clk); #1;
        rst_n = 1;
        checking = 1;
        repeat (3) cyc();
        idle_in();
        cyc();

        // R8: fill array with global writes via controller strobe
        cur_req = "R8";
        for (int i = 0; i < DEPTH; i++) begin
            strobe_ctl = 1; chip_sel = 1; wr_all = 1; addr = AW'(i);
            din = 32'hA500_0000 | (i * 32'h0001_0203);
            cyc();
        end
        idle_in();
        cyc();

        // R2/R9/R4: linear read burst from base 5 with wrap
        cur_req = "R4";
        order_ilv = 0;
        strobe_cpu = 1; chip_sel = 1; addr = 6'd5;
        cyc();
        idle_in();
        for (int i = 0; i < 5; i++) begin burst_adv = 1; cyc(); end
        burst_adv = 0;

        // R6: hold
        cur_req = "R6";
        repeat (3) cyc();

        // R5: interleaved burst from base 22
        cur_req = "R5";
        order_ilv = 1;
        strobe_ctl = 1; chip_sel = 1; addr = 6'd22;
        cyc();
        idle_in();
        for (int i = 0; i < 5; i++) begin burst_adv = 1; cyc(); end
        idle_in();

        // R7: byte lane writes with advance, then read back
        cur_req = "R7";
        order_ilv = 0;
        strobe_ctl = 1; chip_sel = 1; addr = 6'd40; wr_en = 1; byte_sel = 4'b0101;
        din = 32'h1122_3344;
        cyc();
        strobe_ctl = 0; chip_sel = 0; burst_adv = 1; byte_sel = 4'b1000; din = 32'hDEAD_BEEF;
        cyc();
        wr_en = 0; byte_sel = 4'b1111; din = 32'hFFFF_FFFF;   // selects without enable
        cyc();
        idle_in();
        cur_req = "R9";
        strobe_cpu = 1; chip_sel = 1; addr = 6'd40;
        cyc();
        idle_in();
        burst_adv = 1; cyc(); cyc(); cyc();
        idle_in();

        // R8: all byte selects with enable
        cur_req = "R8";
        strobe_ctl = 1; chip_sel = 1; addr = 6'd9; wr_en = 1; byte_sel = 4'hF; din = 32'h0BAD_F00D;
        cyc();
        idle_in(); cyc();
        strobe_cpu = 1; chip_sel = 1; addr = 6'd9; cyc(); idle_in(); cyc();

        // R3: both strobes with write controls -> read, no write
        cur_req = "R3";
        strobe_cpu = 1; strobe_ctl = 1; chip_sel = 1; addr = 6'd12; wr_all = 1; din = 32'h5555_AAAA;
        cyc();
        idle_in(); cyc();
        strobe_cpu = 1; chip_sel = 1; addr = 6'd12; cyc(); idle_in(); cyc();

        // R11: deselect strobe
        cur_req = "R11";
        strobe_ctl = 1; chip_sel = 0; addr = 6'd3; cyc();
        idle_in(); burst_adv = 1; cyc(); cyc(); idle_in();

        // R10: asynchronous oe
        cur_req = "R10";
        strobe_cpu = 1; chip_sel = 1; addr = 6'd30; cyc(); idle_in();
        #(CLK_PERIOD/4); oe = 0; #1; compare();
        #1; oe = 1; #1; compare();
        cyc();

        // R12: sleep ignores inputs and keeps array
        cur_req = "R12";
        sleep = 1;
        strobe_ctl = 1; chip_sel = 1; addr = 6'd30; wr_all = 1; din = 32'h0;
        repeat (4) cyc();
        idle_in(); sleep = 0;
        cyc(); cyc();
        strobe_cpu = 1; chip_sel = 1; addr = 6'd30; cyc(); idle_in(); cyc();

        checking = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule